// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus that fronts a 128 x 8 byte store. The bus lines are sampled on a fast system clock. The bus lines are open-drain: the block reads SDA and SCL and can only pull SDA low, through an output-enable. A master opens each command with a Start. It then addresses the block with a control byte whose upper four bits are 1010. Bit 0 of that byte selects the direction: 0 writes and 1 reads. A write goes on with a word-address byte and any number of data bytes. A read streams bytes from the current address pointer.

Written bytes are not placed in the store straight away. They collect in a sixteen-slot buffer in arrival order. When more than sixteen arrive, the oldest ones are dropped. A Stop that closes a write holding at least one data byte starts an internal programming cycle. A counter of fixed length stands in for that cycle. While it runs, `busy` is high, the buffer is copied into the store, and the slave answers nothing on the bus. A repeated Start between the address and the read gives a random read from any location.

Top module: `serialMemSlave`

## Requirements
- R1: After reset SDA is released and `busy` is low. SCL pulses that arrive without a preceding Start (SDA falling while SCL is high) are never acknowledged.
- R2: A control byte whose upper four bits are 1010 is acknowledged, with bit 0 = 0 for write and 1 for read. Any other upper nibble is not acknowledged, and the slave then stays silent until the next Start.
- R3: Each accepted byte of a write (control, word address, data) is acknowledged. The slave holds SDA low through the whole high phase of the ninth SCL pulse.
- R4: The slave changes its drive on SDA only while SCL is low.
- R5: The low seven bits of the word-address byte load the current address. A read returns bytes MSB first, starting at the current address. The address steps by one per byte and wraps from 127 to 0.
- R6: During a read, a low SDA on the ninth pulse from the master asks for the next byte. A high SDA there makes the slave release SDA and ignore the bus until the next Start.
- R7: Write data bytes belong to consecutive addresses, starting at the word address and wrapping at 127. Only the last 16 bytes of a transfer are stored, and the oldest is displaced first. Locations of displaced bytes keep their old contents.
- R8: Data is committed only by a Stop that ends the write. A Start that arrives before that Stop discards the buffered bytes.
- R9: A Stop ending a write that holds at least one data byte raises `busy` for exactly PROG_CYCLES system clock cycles. A write that carries only a word address leaves `busy` low.
- R10: While `busy` is high, no byte is acknowledged, the control byte included.
- R11: A Start at any point restarts the bit count and expects a new control byte. A repeated Start after the word address therefore gives a random read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired-AND of all drivers) |
| sdaPullLow | output | 1 | High to pull SDA low, low to release it |
| busy | output | 1 | Internal programming cycle in progress |

## Verification
A wrong bit counter or a wrong state shows up at the ports within one byte. The slave either fails to pull SDA during the ninth pulse or pulls it during a data pulse, and the master's acknowledge samples catch this in the same byte time. A wrong address pointer or a wrong buffer index does not show up while the write is happening. It appears as wrong data on the next read of the affected locations. For this reason every write in the bench is followed by a full or windowed read-back against an arithmetic model. A programming counter that is off by even one cycle changes the measured width of `busy`, which is counted exactly after every committed write.

// File: rtl/serialMemPkg.sv
package serialMemPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } busState_t;

  // Strobes from control to datapath, each valid for one system clock.
  typedef struct packed {
    logic shiftIn;    // sample one received bit
    logic shiftTx;    // advance the transmit byte by one bit
    logic loadTx;     // fetch the byte at the current address and step it
    logic setAddr;    // word address byte accepted
    logic pushData;   // write data byte accepted
    logic beginProg;  // Stop ended a write
  } memStrobes_t;

endpackage

// File: rtl/serialMemBusSense.sv
module serialMemBusSense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  // Reset to the idle-bus level so no edge appears when reset is released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclHigh  = sclPipe[SYNC_STAGES-1];
  assign sdaBit   = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclHigh & ~sclPrev;
  assign sclFall  = ~sclHigh & sclPrev;
  assign startDet = sclHigh & sclPrev & sdaPrev & ~sdaBit;
  assign stopDet  = sclHigh & sclPrev & ~sdaPrev & sdaBit;

endmodule

// File: rtl/serialMemCtrl.sv
module serialMemCtrl
  import serialMemPkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclHigh,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaBit,
  input  logic [3:0]  rxPrefix,
  input  logic        rxLsb,
  input  logic        txBit,
  input  logic        busy,
  output memStrobes_t stb,
  output logic        pullLow
);

  // Pulse count in the current nine-pulse frame:
  // 1..8 after data rises, 9 after the acknowledge rise.
  localparam logic [3:0] BYTE_DONE = 4'd8;
  localparam logic [3:0] ACK_SLOT  = 4'd9;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       isRead, ackDrive, txDrive;
  logic       receiving, accept;

  assign receiving = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WDATA);
  assign accept    = !busy && ((state != ST_CTRL) || (rxPrefix == DEV_PREFIX));

  always_comb begin
    stb           = '0;
    stb.shiftIn   = receiving && sclRise && (bitCnt < BYTE_DONE);
    stb.setAddr   = (state == ST_ADDR)  && sclFall && (bitCnt == BYTE_DONE) && !busy;
    stb.pushData  = (state == ST_WDATA) && sclFall && (bitCnt == BYTE_DONE) && !busy;
    stb.loadTx    = sclFall && (bitCnt == ACK_SLOT) &&
                    (((state == ST_CTRL) && isRead) || (state == ST_RDATA));
    stb.shiftTx   = (state == ST_RDATA) && sclFall && (bitCnt != 4'd0) && (bitCnt < BYTE_DONE);
    stb.beginProg = stopDet && (state == ST_WDATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else if (startDet) begin
      state    <= ST_CTRL;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else if ((state != ST_IDLE) && (state != ST_IGNORE)) begin
      if (sclRise) begin
        if ((state == ST_RDATA) && (bitCnt == BYTE_DONE) && sdaBit) begin
          state  <= ST_IGNORE;
          bitCnt <= '0;
        end else if (bitCnt < ACK_SLOT) begin
          bitCnt <= bitCnt + 4'd1;
        end
      end else if (sclFall) begin
        if (bitCnt == BYTE_DONE) begin
          if (state == ST_RDATA) begin
            txDrive <= 1'b0;
          end else if (accept) begin
            ackDrive <= 1'b1;
            if (state == ST_CTRL) isRead <= rxLsb;
          end else begin
            state  <= ST_IGNORE;
            bitCnt <= '0;
          end
        end else if (bitCnt == ACK_SLOT) begin
          bitCnt   <= '0;
          ackDrive <= 1'b0;
          unique case (state)
            ST_CTRL: begin
              state   <= isRead ? ST_RDATA : ST_ADDR;
              txDrive <= isRead;
            end
            ST_ADDR:  state   <= ST_WDATA;
            ST_RDATA: txDrive <= 1'b1;
            default:  ;
          endcase
        end
      end
    end
  end

  assign pullLow = ackDrive | (txDrive & ~txBit);

  // R1: idle or ignoring, the slave never pulls the line.
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) || (state == ST_IGNORE)) |-> !pullLow);

  // R3: acknowledge held low across the whole ninth high phase of a write byte.
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (receiving && (bitCnt == ACK_SLOT) && sclHigh) |-> pullLow);

  // R4: drive changes only follow a low clock (Start/Stop release excepted).
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclHigh) && !$past(startDet) && !$past(stopDet)) |-> $stable(pullLow));

  // R6: a master NACK ends the read and leaves SDA released.
  p_nack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RDATA) && sclRise && (bitCnt == BYTE_DONE) && sdaBit)
      |=> ((state == ST_IGNORE) && !pullLow));

  // R10: no acknowledge is ever driven during programming.
  p_silent_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ackDrive);

endmodule

// File: rtl/serialMemDatapath.sv
module serialMemDatapath
  import serialMemPkg::*;
#(
  parameter int MEM_DEPTH   = 128,
  parameter int PAGE_SLOTS  = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  memStrobes_t stb,
  input  logic        sdaBit,
  output logic [3:0]  rxPrefix,
  output logic        rxLsb,
  output logic        txBit,
  output logic        busy
);

  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int PTR_W  = $clog2(PAGE_SLOTS);
  localparam int CNT_W  = $clog2(PAGE_SLOTS + 1);
  localparam int PCNT_W = $clog2(PROG_CYCLES + 1);

  logic [7:0]        rxShift, txShift;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        slotData [PAGE_SLOTS];
  logic [7:0]        mem      [MEM_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  fillCnt, commitIdx;
  logic [PCNT_W-1:0] progCnt;
  logic              busyQ, commitWe;
  logic [ADDR_W-1:0] commitAddr;
  logic [PTR_W-1:0]  commitSlot;

  // Kept bytes are the fillCnt most recent ones; the address pointer already
  // stands one past the newest, so the oldest kept byte sits fillCnt below it.
  assign commitWe   = busyQ && (commitIdx < fillCnt);
  assign commitAddr = curAddr - ADDR_W'(fillCnt) + ADDR_W'(commitIdx);
  assign commitSlot = wrPtr - PTR_W'(fillCnt) + PTR_W'(commitIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      curAddr   <= '0;
      wrPtr     <= '0;
      fillCnt   <= '0;
      commitIdx <= '0;
      progCnt   <= '0;
      busyQ     <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};

      if (stb.loadTx) begin
        txShift <= mem[curAddr];
        curAddr <= curAddr + 1'b1;
      end else if (stb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
      end

      if (stb.setAddr) begin
        curAddr <= rxShift[ADDR_W-1:0];
        wrPtr   <= '0;
        fillCnt <= '0;
      end else if (stb.pushData) begin
        curAddr <= curAddr + 1'b1;
        wrPtr   <= wrPtr + 1'b1;
        if (fillCnt < CNT_W'(PAGE_SLOTS)) fillCnt <= fillCnt + 1'b1;
      end

      if (stb.beginProg && (fillCnt != '0)) begin
        busyQ     <= 1'b1;
        progCnt   <= '0;
        commitIdx <= '0;
      end else if (busyQ) begin
        if (commitWe) commitIdx <= commitIdx + 1'b1;
        if (progCnt == PCNT_W'(PROG_CYCLES - 1)) begin
          busyQ   <= 1'b0;
          fillCnt <= '0;
        end else begin
          progCnt <= progCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.pushData) slotData[wrPtr] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (commitWe) mem[commitAddr] <= slotData[commitSlot];
  end

  assign rxPrefix = rxShift[7:4];
  assign rxLsb    = rxShift[0];
  assign txBit    = txShift[7];
  assign busy     = busyQ;

  // R7: the buffer never claims more bytes than it has slots.
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(PAGE_SLOTS));

  // R9: a Stop closing a write with data starts programming on the next cycle.
  p_busy_after_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beginProg && (fillCnt != '0)) |=> busy);

  // R10: no write byte is taken while the store is being programmed.
  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !(stb.pushData || stb.setAddr));

endmodule

// File: rtl/serialMemSlave.sv
module serialMemSlave
  import serialMemPkg::*;
#(
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter int         MEM_DEPTH   = 128,
  parameter int         PAGE_SLOTS  = 16,
  parameter int         PROG_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  output logic busy
);

  logic        sclHigh, sdaBit, sclRise, sclFall, startDet, stopDet;
  logic [3:0]  rxPrefix;
  logic        rxLsb, txBit;
  memStrobes_t stb;

  serialMemBusSense #(.SYNC_STAGES(SYNC_STAGES)) uSense (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclHigh  (sclHigh),
    .sdaBit   (sdaBit),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  serialMemCtrl #(.DEV_PREFIX(DEV_PREFIX)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclHigh  (sclHigh),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaBit   (sdaBit),
    .rxPrefix (rxPrefix),
    .rxLsb    (rxLsb),
    .txBit    (txBit),
    .busy     (busy),
    .stb      (stb),
    .pullLow  (sdaPullLow)
  );

  serialMemDatapath #(
    .MEM_DEPTH   (MEM_DEPTH),
    .PAGE_SLOTS  (PAGE_SLOTS),
    .PROG_CYCLES (PROG_CYCLES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdaBit   (sdaBit),
    .rxPrefix (rxPrefix),
    .rxLsb    (rxLsb),
    .txBit    (txBit),
    .busy     (busy)
  );

endmodule

// File: tb/sim_serialMemSlave.sv
`timescale 1ns/1ps
module sim_serialMemSlave;

  localparam int PROG = 400;
  localparam int Q    = 8;     // quarter SCL period in system clocks
  localparam int WD   = 195000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaIn, sdaPullLow, busy;
  int   total = 0, bad = 0, r4Viol = 0;
  bit   done = 0;
  logic [7:0] expMem [128];

  always #2.5 clk = ~clk;
  assign sdaIn = sdaM & ~sdaPullLow;

  serialMemSlave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .busy(busy)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  // R4 monitor: the slave's drive must hold while SCL stays high.
  logic lastScl = 1'b1, lastPull = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && lastScl && (sdaPullLow !== lastPull)) r4Viol++;
    lastScl  = sclM;
    lastPull = sdaPullLow;
  end

  task automatic startCond();
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); sdaM = 1'b0; qw(); sclM = 1'b0; qw();
  endtask

  task automatic stopPlain();
    sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1; qw();
  endtask

  task automatic stopMeasure(input string req);
    int n = 0, cnt = 0;
    sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    check(busy == 1'b1, req, int'(busy), 1);
    while (busy && cnt < 2 * PROG) begin cnt++; @(negedge clk); end
    check(cnt == PROG, req, cnt, PROG);
    qw();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qw(); sclM = 1'b1; qw(); qw(); sclM = 1'b0; qw();
    end
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); a1 = sdaIn; qw(); a2 = sdaIn; sclM = 1'b0; qw();
    acked = !a1 && !a2;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; qw(); sclM = 1'b1; qw(); b[i] = sdaIn; qw(); sclM = 1'b0; qw();
    end
    sdaM = giveAck ? 1'b0 : 1'b1; qw(); sclM = 1'b1; qw(); qw(); sclM = 1'b0; qw();
    sdaM = 1'b1;
  endtask

  task automatic sendExpect(input logic [7:0] b, input bit expAck, input string req);
    bit a;
    sendByte(b, a);
    check(a == expAck, req, int'(a), int'(expAck));
  endtask

  // Random read through a repeated Start (R11), compared against the model (R5).
  task automatic readSeq(input int addr, input int n, input string req);
    logic [7:0] d;
    startCond();
    sendExpect(8'hA0, 1'b1, "R2");
    sendExpect(8'(addr), 1'b1, "R3");
    startCond();
    sendExpect(8'hA1, 1'b1, "R11");
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d);
      check(d == expMem[(addr + k) % 128], req, int'(d), int'(expMem[(addr + k) % 128]));
    end
    // R6: after the NACK the slave stays off the line for a further pulse.
    check(sdaPullLow == 1'b0, "R6", int'(sdaPullLow), 0);
    qw(); sclM = 1'b1; qw();
    check(sdaIn == 1'b1, "R6", int'(sdaIn), 1);
    qw(); sclM = 1'b0; qw();
    stopPlain();
  endtask

  task automatic writeSeq(input int addr, input int n, input logic [7:0] base);
    startCond();
    sendExpect(8'hA0, 1'b1, "R2");
    sendExpect(8'(addr), 1'b1, "R3");
    for (int k = 0; k < n; k++) sendExpect(8'(base + k), 1'b1, "R3");
    // R7: only the last sixteen bytes land, each at its own sequential address.
    for (int k = (n > 16 ? n - 16 : 0); k < n; k++) expMem[(addr + k) % 128] = 8'(base + k);
  endtask

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    check(sdaPullLow == 1'b0 && busy == 1'b0, "R1", int'({sdaPullLow, busy}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: a full byte with no Start is never acknowledged.
    sendByte(8'hA0, a);
    check(a == 1'b0, "R1", int'(a), 0);
    qw(); sclM = 1'b1; qw();

    // Fill the whole store page by page with an arithmetic pattern.
    for (int p = 0; p < 8; p++) begin
      startCond();
      sendExpect(8'hA0, 1'b1, "R2");
      sendExpect(8'(16 * p), 1'b1, "R3");
      for (int k = 0; k < 16; k++) begin
        sendExpect(pat(16 * p + k), 1'b1, "R3");
        expMem[16 * p + k] = pat(16 * p + k);
      end
      stopMeasure("R9");
    end

    // R5: sweep every location and wrap past 127 back to 0.
    readSeq(0, 130, "R5");

    // R10: during programming even a matching control byte gets no acknowledge.
    writeSeq(8'h10, 1, 8'h5A);
    stopPlain();
    check(busy == 1'b1, "R9", int'(busy), 1);
    startCond();
    sendExpect(8'hA0, 1'b0, "R10");
    sendExpect(8'h10, 1'b0, "R10");
    stopPlain();
    while (busy) @(negedge clk);
    readSeq(8'h0E, 4, "R9");

    // R7: twenty bytes, the first four displaced.
    writeSeq(8'h40, 20, 8'hA0);
    stopMeasure("R9");
    readSeq(8'h3E, 24, "R7");

    // R7: write crossing the top of the store wraps to 0.
    writeSeq(8'h7E, 3, 8'hC1);
    stopMeasure("R9");
    readSeq(8'h7D, 5, "R7");

    // R2: wrong prefix is refused and the slave ignores the rest.
    startCond();
    sendExpect(8'hB0, 1'b0, "R2");
    sendExpect(8'h00, 1'b0, "R2");
    stopPlain();
    startCond();
    sendExpect(8'h20, 1'b0, "R2");
    stopPlain();
    check(busy == 1'b0, "R2", int'(busy), 0);

    // R9: address-only write starts no programming.
    startCond();
    sendExpect(8'hA0, 1'b1, "R2");
    sendExpect(8'h05, 1'b1, "R3");
    stopPlain();
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R9", int'(busy), 0);

    // R8/R11: a repeated Start abandons buffered data; the read continues from the pointer.
    begin
      logic [7:0] d;
      startCond();
      sendExpect(8'hA0, 1'b1, "R2");
      sendExpect(8'h20, 1'b1, "R3");
      sendExpect(8'h11, 1'b1, "R3");
      sendExpect(8'h22, 1'b1, "R3");
      startCond();
      sendExpect(8'hA1, 1'b1, "R11");
      recvByte(1'b0, d);
      check(d == expMem[8'h22], "R11", int'(d), int'(expMem[8'h22]));
      stopPlain();
      repeat (20) @(negedge clk);
      check(busy == 1'b0, "R8", int'(busy), 0);
      readSeq(8'h20, 2, "R8");
    end

    check(r4Viol == 0, "R4", r4Viol, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule